// File: doc/BRIEF.md
# I2C SCL Timebase

This block turns the peripheral clock into the bit timing of an I2C master. A prescaler divides the input clock by `CDF+1` to form an internal tick. A phase timer then counts ticks to shape each SCL period. One period is 20 fixed ticks, plus 8 ticks per unit of a coarse step field, plus a small compensation count. The low phase takes the larger half of the period.

When the master is switched on, the block first waits a programmable number of input clock cycles. This is the window between the SDA start edge, driven by the master controller, and the first SCL falling edge. After that the block produces SCL low/high phases with one-cycle fall and rise strobes for as long as the run input stays high.

The SCL line is sampled back through a synchronizer. The high phase only starts counting once the line is really seen high, so a target that holds SCL low stretches the clock. While the run input is low, all counters are held cleared. Every transfer therefore starts from the same phase.

Top module: `scl_timebase`

## Requirements
- R1: While `rst_n` is low, and from the cycle after `run_i` is seen low, `scl_o` is 1 and `tick_o`, `fall_o`, `rise_o` and `setup_busy_o` are 0.
- R2: While SCL is being generated, `tick_o` pulses for one cycle once every `CDF+1` input clock cycles. `CDF` is `clk_cfg_i[2:0]`. The first tick of a low phase falls in its `CDF+1`-th cycle.
- R3: One SCL period is P = 20 + 8×STEP + COMP internal ticks. STEP is `clk_cfg_i[8:3]` (0 to 63) and COMP is `comp_i` (0 to 15). Successive periods repeat with the same length.
- R4: The low phase lasts ceil(P/2) ticks, that is ceil(P/2)×(CDF+1) input cycles, and contains exactly ceil(P/2) tick strobes.
- R5: The high phase lasts floor(P/2) ticks. These ticks are counted only once the synchronized line reads high. With the line following `scl_o`, the phase lasts SYNC_STAGES + floor(P/2)×(CDF+1) cycles (SYNC_STAGES is 2 by default).
- R6: After `run_i` is sampled high in idle, `setup_busy_o` is high for `setup_code_i`+2 cycles (code 15 gives 17). SCL falls in the cycle after the last busy cycle.
- R7: If `scl_in_i` is held low for X cycles beyond the point where it would have risen, the high phase grows by exactly X cycles.
- R8: Dropping `run_i` during a transfer returns the block to idle on the next cycle. A later start repeats the full setup delay and a full-length first low phase.
- R9: `fall_o` is high exactly in the first cycle of each SCL low phase, and `rise_o` exactly in the first cycle of each high phase entered from low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Master interface enable; low holds all counters cleared |
| clk_cfg_i | input | 9 | Divider field: [2:0] prescale CDF, [8:3] coarse step STEP |
| comp_i | input | 4 | Rise/fall compensation ticks added to the period |
| setup_code_i | input | 4 | First-bit setup code; delay is code+2 input cycles |
| scl_in_i | input | 1 | SCL line level sampled back from the pad |
| tick_o | output | 1 | Internal tick strobe |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| fall_o | output | 1 | Strobe in the first cycle of an SCL low phase |
| rise_o | output | 1 | Strobe in the first cycle of an SCL high phase |
| setup_busy_o | output | 1 | High during the first-bit setup window |

## Verification
Some properties are checked on every cycle by assertions:
- the idle release after `run_i` drops;
- the one-cycle spacing limit on ticks;
- the phase counter never reaching its target;
- the setup counter tracking the controller state;
- the high phase being frozen while the sampled line is low;
- the strobes lining up with the SCL edges.

The exact cycle counts of the setup window, of the low and high phases, of the full period under different divider and step settings, and of the extension caused by a stretching target can only be shown by the bench's scenarios. The same holds for the repeated setup after an aborted transfer.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_LOW   = 2'd2,
      ST_HIGH  = 2'd3
   } scl_state_e;

   // fixed part of one SCL period and ticks added per coarse step
   localparam int BASE_TICKS = 20;
   localparam int STEP_TICKS = 8;
   // setup delay is code plus this many input cycles
   localparam int SETUP_EXTRA = 2;

endpackage

// File: rtl/scl_tb_sync.sv
module scl_tb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("scl_tb_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b1;
         else        s_q <= d_i;
      end
      assign q_o = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
      assign q_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/scl_tb_prescale.sv
module scl_tb_prescale #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [PRE_W-1:0] div_i,
   output logic             tick_o
);

   if (PRE_W < 1) begin : g_bad_width
      $error("scl_tb_prescale: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] cnt_q;

   assign tick_o = !clr_i && (cnt_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // with a divide ratio above one, two ticks never follow back to back
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/scl_tb_phase.sv
module scl_tb_phase #(
   parameter int PER_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [PER_W-1:0] target_i,
   output logic             expire_o
);

   if (PER_W < 2) begin : g_bad_width
      $error("scl_tb_phase: PER_W must be at least 2");
   end

   logic [PER_W-1:0] cnt_q;

   assign expire_o = !clr_i && tick_i && (cnt_q == target_i - PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr_i)    cnt_q <= '0;
      else if (expire_o) cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + 1'b1;
   end

   // with stable settings the count of a running phase stays below its length
   assert_cnt_below_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |-> (cnt_q < target_i));

endmodule

// File: rtl/scl_tb_setup.sv
module scl_tb_setup #(
   parameter int SETUP_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               start_i,
   input  logic [SETUP_W-1:0] code_i,
   output logic               busy_o,
   output logic               done_o
);

   if (SETUP_W < 1) begin : g_bad_width
      $error("scl_tb_setup: SETUP_W must be at least 1");
   end

   localparam int CNT_W = SETUP_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             act_q;

   assign busy_o = act_q;
   assign done_o = act_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (clear_i) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i && !act_q) begin
         act_q <= 1'b1;
         cnt_q <= CNT_W'(code_i) + CNT_W'(scl_timebase_pkg::SETUP_EXTRA - 1);
      end else if (done_o) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !clear_i) |=> busy_o);

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase
   import scl_timebase_pkg::*;
#(
   parameter int PRE_W       = 3,
   parameter int STEP_W      = 6,
   parameter int COMP_W      = 4,
   parameter int SETUP_W     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run_i,
   input  logic [PRE_W+STEP_W-1:0]   clk_cfg_i,
   input  logic [COMP_W-1:0]         comp_i,
   input  logic [SETUP_W-1:0]        setup_code_i,
   input  logic                      scl_in_i,
   output logic                      tick_o,
   output logic                      scl_o,
   output logic                      fall_o,
   output logic                      rise_o,
   output logic                      setup_busy_o
);

   localparam int PER_MAX = BASE_TICKS + STEP_TICKS * ((1 << STEP_W) - 1)
                          + ((1 << COMP_W) - 1);
   localparam int PER_W   = $clog2(PER_MAX + 1);

   if (STEP_W < 1 || COMP_W < 1) begin : g_bad_fields
      $error("scl_timebase: STEP_W and COMP_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("scl_timebase: SYNC_STAGES must be at least 1");
   end

   // ---------------- field decode and period arithmetic ----------------
   logic [PRE_W-1:0]  cdf;
   logic [STEP_W-1:0] step;
   logic [PER_W-1:0]  period;
   logic [PER_W:0]    period_up;
   logic [PER_W-1:0]  lo_len;
   logic [PER_W-1:0]  hi_len;

   assign cdf       = clk_cfg_i[PRE_W-1:0];
   assign step      = clk_cfg_i[PRE_W +: STEP_W];
   assign period    = PER_W'(BASE_TICKS) + PER_W'(step) * PER_W'(STEP_TICKS)
                    + PER_W'(comp_i);
   assign period_up = {1'b0, period} + 1'b1;
   assign lo_len    = period_up[PER_W:1];
   assign hi_len    = period >> 1;

   // ---------------- state and submodule wiring ----------------
   scl_state_e state_q, state_d;
   logic       line_hi;
   logic       pre_clr, ph_clr, tick, expire;
   logic       setup_start, setup_busy, setup_done;
   logic [PER_W-1:0] ph_target;

   assign pre_clr     = !((state_q == ST_LOW) || (state_q == ST_HIGH && line_hi));
   assign ph_clr      = !((state_q == ST_LOW) || (state_q == ST_HIGH));
   assign ph_target   = (state_q == ST_HIGH) ? hi_len : lo_len;
   assign setup_start = (state_q == ST_IDLE) && run_i;

   scl_tb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (scl_in_i),
      .q_o   (line_hi)
   );

   scl_tb_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (pre_clr),
      .div_i  (cdf),
      .tick_o (tick)
   );

   scl_tb_phase #(.PER_W(PER_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (ph_clr),
      .tick_i   (tick),
      .target_i (ph_target),
      .expire_o (expire)
   );

   scl_tb_setup #(.SETUP_W(SETUP_W)) u_setup (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (!run_i),
      .start_i (setup_start),
      .code_i  (setup_code_i),
      .busy_o  (setup_busy),
      .done_o  (setup_done)
   );

   // ---------------- phase sequencing ----------------
   always_comb begin
      state_d = state_q;
      if (!run_i) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  state_d = ST_SETUP;
            ST_SETUP: if (setup_done) state_d = ST_LOW;
            ST_LOW:   if (expire)     state_d = ST_HIGH;
            ST_HIGH:  if (expire)     state_d = ST_LOW;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   logic scl_q, fall_q, rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         scl_q   <= 1'b1;
         fall_q  <= 1'b0;
         rise_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         scl_q   <= (state_d != ST_LOW);
         fall_q  <= (state_d == ST_LOW) && (state_q != ST_LOW);
         rise_q  <= (state_q == ST_LOW) && (state_d == ST_HIGH);
      end
   end

   assign tick_o       = tick;
   assign scl_o        = scl_q;
   assign fall_o       = fall_q;
   assign rise_o       = rise_q;
   assign setup_busy_o = (state_q == ST_SETUP);

   // ---------------- assertions ----------------
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (scl_o && !setup_busy_o && !fall_o && !rise_o && !tick_o));

   assert_setup_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
      setup_busy == (state_q == ST_SETUP));

   assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HIGH && !line_hi && run_i) |=> (state_q == ST_HIGH));

   assert_fall_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> (!scl_o && $past(scl_o)));

   assert_rise_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (scl_o && !$past(scl_o)));

endmodule

// File: tb/sim_scl_timebase.sv
`timescale 1ns/1ps
module sim_scl_timebase;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_i = 1'b0;
   logic [8:0] clk_cfg_i = '0;
   logic [3:0] comp_i = '0;
   logic [3:0] setup_code_i = '0;
   logic       hold_line = 1'b0;
   logic       scl_in_i;
   logic       tick_o, scl_o, fall_o, rise_o, setup_busy_o;

   assign scl_in_i = scl_o & ~hold_line;

   always #2 clk = ~clk;

   scl_timebase #(.SYNC_STAGES(SYNC)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run_i),
      .clk_cfg_i    (clk_cfg_i),
      .comp_i       (comp_i),
      .setup_code_i (setup_code_i),
      .scl_in_i     (scl_in_i),
      .tick_o       (tick_o),
      .scl_o        (scl_o),
      .fall_o       (fall_o),
      .rise_o       (rise_o),
      .setup_busy_o (setup_busy_o)
   );

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // {cdf, step, comp, setup code, stretch cycles, expected period in ticks}
   localparam logic [34:0] VEC [6] = '{
      {3'd0, 6'd0,  4'd0,  4'd15, 8'd0, 10'd20},
      {3'd1, 6'd1,  4'd3,  4'd0,  8'd0, 10'd31},
      {3'd3, 6'd2,  4'd5,  4'd7,  8'd0, 10'd41},
      {3'd2, 6'd0,  4'd1,  4'd3,  8'd5, 10'd21},
      {3'd7, 6'd63, 4'd15, 4'd1,  8'd0, 10'd539},
      {3'd0, 6'd5,  4'd0,  4'd2,  8'd3, 10'd60}
   };

   task automatic run_vec(input logic [34:0] v);
      int cdf, step, comp, code, str, per, d, lo, hi;
      int n, ticks, badgap, lo_cyc, hi_cyc;
      cdf  = int'(v[34:32]);
      step = int'(v[31:26]);
      comp = int'(v[25:22]);
      code = int'(v[21:18]);
      str  = int'(v[17:10]);
      per  = int'(v[9:0]);
      d    = cdf + 1;
      lo   = (per + 1) / 2;
      hi   = per / 2;
      @(negedge clk);
      run_i        = 1'b0;
      clk_cfg_i    = {6'(step), 3'(cdf)};
      comp_i       = 4'(comp);
      setup_code_i = 4'(code);
      repeat (3) @(negedge clk);
      hold_line = (str != 0);
      run_i     = 1'b1;
      // setup window (R6)
      n = 0;
      @(negedge clk);
      while (setup_busy_o) begin n++; @(negedge clk); end
      check("R6 setup length", n, code + 2);
      check("R9 fall strobe at first low", int'(fall_o), 1);
      // first low phase (R4, R2)
      n = 0; ticks = 0; badgap = 0;
      while (!scl_o) begin
         n++;
         if (tick_o) begin
            ticks++;
            if (n % d != 0) badgap++;
         end
         @(negedge clk);
      end
      lo_cyc = n;
      check("R4 low phase cycles", lo_cyc, lo * d);
      check("R4 ticks in low phase", ticks, lo);
      check("R2 tick spacing errors", badgap, 0);
      check("R9 rise strobe at high", int'(rise_o), 1);
      // high phase with optional stretch (R5, R7)
      n = 0;
      while (scl_o) begin
         n++;
         if (hold_line && n == str + 1) hold_line = 1'b0;
         @(negedge clk);
      end
      hi_cyc = n;
      if (str != 0)
         check("R7 stretched high cycles", hi_cyc, SYNC + str + hi * d);
      else
         check("R5 high phase cycles", hi_cyc, SYNC + hi * d);
      check("R3 period cycles", lo_cyc + hi_cyc, per * d + SYNC + str);
      check("R3 period formula", per, 20 + 8 * step + comp);
      check("R9 fall strobe next period", int'(fall_o), 1);
      // second low phase repeats (R3)
      n = 0;
      while (!scl_o) begin n++; @(negedge clk); end
      check("R3 repeated low phase", n, lo * d);
      run_i = 1'b0;
      @(negedge clk);
      check("R1 idle after run low", int'(scl_o), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R1)
      check("R1 reset scl", int'(scl_o), 1);
      check("R1 reset strobes", int'(fall_o | rise_o | tick_o | setup_busy_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // settings move while idle: nothing happens (R1)
      for (int k = 0; k < 6; k++) begin
         clk_cfg_i = 9'(k * 37);
         comp_i    = 4'(k);
         @(negedge clk);
         check("R1 idle outputs", int'({scl_o, fall_o, rise_o, tick_o, setup_busy_o}), 16);
      end
      // vector table
      for (int i = 0; i < 6; i++) run_vec(VEC[i]);
      // abort mid-low then restart (R8)
      @(negedge clk);
      clk_cfg_i = 9'd0; comp_i = 4'd0; setup_code_i = 4'd4; hold_line = 1'b0;
      run_i = 1'b1;
      @(negedge clk);
      while (setup_busy_o) @(negedge clk);
      repeat (5) @(negedge clk);
      check("R8 still low before abort", int'(scl_o), 0);
      run_i = 1'b0;
      @(negedge clk);
      check("R8 released after abort", int'(scl_o), 1);
      check("R8 no strobes after abort", int'(tick_o | fall_o | rise_o | setup_busy_o), 0);
      repeat (2) @(negedge clk);
      run_i = 1'b1;
      begin
         int n;
         n = 0;
         @(negedge clk);
         while (setup_busy_o) begin n++; @(negedge clk); end
         check("R8 restart setup length", n, 6);
         n = 0;
         while (!scl_o) begin n++; @(negedge clk); end
         check("R8 restart full low phase", n, 10);
      end
      run_i = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule